// File: doc/BRIEF.md
# USB Full-Speed Frame Interval Timer

This block produces the 1 ms frame timing of a USB full-speed host controller. A down-counter holding the remaining bit times is decremented on every bit-time tick. When it reaches zero it reloads from the programmed frame interval, advances a 16-bit frame number, and sends start-of-frame and frame-number-overflow pulses on an event vector. Two threshold comparisons run against the remaining count. One opens the window for periodic list processing. The other marks the period in which a low-speed packet may still be started.

Software reaches five registers through a plain 32-bit read/write port. The interval register holds the bit-time count, a largest-data-packet field and a toggle flag that software inverts on each rewrite. A new interval is only a pending value until the next reload, so a rewrite never shortens or stretches the frame already in progress. The counter and frame number advance only while the `run` input marks the controller as operational.

Top module: `frame_timer`

## Requirements
- R1: After reset the registers read as follows. Interval (address 0) reads 0x27782EDF: bit-time count 0x2EDF in [13:0], largest-packet field 0x2778 in [30:16], toggle bit [31] = 0. Remaining (address 1) reads 0x00002EDF. Frame number (address 2) reads 0. Periodic start (address 3) reads 0x2A2F. Low-speed threshold (address 4) reads 0x628. The event vector is zero.
- R2: While `run` is high, every cycle with `tick` high decrements the remaining count in [13:0] of address 1. A tick that finds the count at zero loads it with the interval's bit-time count instead, so one frame lasts count+1 ticks.
- R3: A write to the interval register does not change the remaining count in the frame under way. The new count is used only at the next reload.
- R4: After each reload, bit 31 of the remaining register equals bit 31 of the interval register as it stood when the reload happened.
- R5: Each reload increments the frame number by one, wrapping from 0xFFFF to 0. Address 2 reads the number in [15:0] with [31:16] zero. A write to address 2 loads [15:0] directly and takes precedence over a reload in the same cycle.
- R6: Bit 2 of `events` is high for exactly the one cycle after each reload.
- R7: Bit 5 of `events` is high for the one cycle after a reload that changes bit 15 of the frame number (0x7FFF to 0x8000, and 0xFFFF to 0). It is never high without bit 2. All other event bits stay zero.
- R8: `periodic_win` is high exactly when the remaining count is less than or equal to the periodic-start value in [13:0] of address 3.
- R9: `ls_ok` is high exactly when the remaining count is strictly greater than the low-speed threshold in [11:0] of address 4.
- R10: While `run` is low, the remaining count and the frame number hold their values and no events are raised, whatever `tick` does.
- R11: Addresses 1 and 2 are only written where R5 allows. Writes to address 1 are ignored. Writes to addresses 3 and 4 store the masked field, which then reads back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Controller operational; timer advances only when high |
| tick | input | 1 | One-cycle bit-time enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0 interval, 1 remaining, 2 frame number, 3 periodic start, 4 low-speed threshold) |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr`, combinational |
| events | output | 8 | Event pulses: bit 2 start of frame, bit 5 frame-number overflow |
| periodic_win | output | 1 | Remaining count at or below periodic start |
| ls_ok | output | 1 | Remaining count above low-speed threshold |

## Verification
A wrong remaining count shows at once on `periodic_win` and `ls_ok` once a threshold is crossed. It also shows at the latest at the next reload, as a start-of-frame pulse in the wrong cycle. A wrong frame number or toggle mirror can hide until the register is read, or until bit 15 is crossed, so the bench reads the remaining and frame registers every cycle. It also preloads the frame number just below both bit-15 transitions. A reload that takes a pending interval too early shows as a frame shorter or longer than the interval value in force.

// File: rtl/ft_pkg.sv
// Package: shared widths, register addresses, reset defaults and event bit
// positions for the frame interval timer.
package ft_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int CNT_W  = 14;  // bit-time count width
    localparam int PKT_W  = 15;  // largest-data-packet field width
    localparam int FN_W   = 16;  // frame number width
    localparam int LS_W   = 12;  // low-speed threshold width
    localparam int EV_W   = 8;   // event vector width
    localparam int EV_SOF = 2;   // start-of-frame event bit
    localparam int EV_FNO = 5;   // frame-number-overflow event bit
    localparam int PKT_LSB = 16;

    localparam logic [CNT_W-1:0] DEF_CNT = 14'h2EDF;
    localparam logic [PKT_W-1:0] DEF_PKT = PKT_W'((6 * (int'(DEF_CNT) - 210)) / 7);
    localparam logic [CNT_W-1:0] DEF_PS  = CNT_W'((9 * int'(DEF_CNT)) / 10);
    localparam logic [LS_W-1:0]  DEF_LS  = 12'h628;

    typedef enum logic [ADDR_W-1:0] {
        RA_IVL  = 3'd0,
        RA_REM  = 3'd1,
        RA_FNUM = 3'd2,
        RA_PST  = 3'd3,
        RA_LST  = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/ft_regs.sv
// Module: software-programmed settings of the frame timer: the pending
// interval (count, largest packet, toggle), periodic start and low-speed
// threshold. Assumes one write per cycle; writes land on the clock edge.
module ft_regs
    import ft_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  ivl_cnt,
    output logic [PKT_W-1:0]  ivl_pkt,
    output logic              ivl_tog,
    output logic [CNT_W-1:0]  pst_cnt,
    output logic [LS_W-1:0]   ls_cnt
);
    // Register writes with synchronous reset to the default frame settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivl_cnt <= DEF_CNT;
            ivl_pkt <= DEF_PKT;
            ivl_tog <= 1'b0;
            pst_cnt <= DEF_PS;
            ls_cnt  <= DEF_LS;
        end else if (wr_en) begin
            case (addr)
                RA_IVL: begin
                    ivl_cnt <= wdata[CNT_W-1:0];
                    ivl_pkt <= wdata[PKT_LSB +: PKT_W];
                    ivl_tog <= wdata[DATA_W-1];
                end
                RA_PST: pst_cnt <= wdata[CNT_W-1:0];
                RA_LST: ls_cnt  <= wdata[LS_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ft_counter.sv
// Module: remaining-time down-counter, active toggle mirror, frame number
// and event pulses. Assumes the pending interval is only sampled at reload.
module ft_counter
    import ft_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] pend_cnt,
    input  logic             pend_tog,
    input  logic             fn_wr,
    input  logic [FN_W-1:0]  fn_wdata,
    output logic [CNT_W-1:0] rem_cnt,
    output logic             act_tog,
    output logic [FN_W-1:0]  fnum,
    output logic             sof,
    output logic             fno
);
    logic            step;
    logic            reload;
    logic [FN_W-1:0] fn_inc;

    // Decode the advance and reload conditions for this cycle.
    always_comb begin
        step   = run && tick;
        reload = step && (rem_cnt == '0);
        fn_inc = fnum + 1'b1;
    end

    // Remaining count: decrement per tick, reload from the pending interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_cnt <= DEF_CNT;
            act_tog <= 1'b0;
        end else if (reload) begin
            rem_cnt <= pend_cnt;
            act_tog <= pend_tog;
        end else if (step) begin
            rem_cnt <= rem_cnt - 1'b1;
        end
    end

    // Frame number: software load wins over the reload increment.
    always_ff @(posedge clk) begin
        if (!rst_n)       fnum <= '0;
        else if (fn_wr)   fnum <= fn_wdata;
        else if (reload)  fnum <= fn_inc;
    end

    // Event pulses raised in the cycle after a reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sof <= 1'b0;
            fno <= 1'b0;
        end else begin
            sof <= reload;
            fno <= reload && !fn_wr && (fn_inc[FN_W-1] != fnum[FN_W-1]);
        end
    end
endmodule

// File: rtl/ft_window.sv
// Module: threshold comparators on the remaining count. Purely combinational;
// assumes thresholds and count are from the same clock domain.
module ft_window
    import ft_pkg::*;
(
    input  logic [CNT_W-1:0] rem_cnt,
    input  logic [CNT_W-1:0] pst_cnt,
    input  logic [LS_W-1:0]  ls_cnt,
    output logic             periodic_win,
    output logic             ls_ok
);
    localparam int LS_PAD = CNT_W - LS_W;

    // Compare the count against both thresholds.
    always_comb begin
        periodic_win = (rem_cnt <= pst_cnt);
        ls_ok        = (rem_cnt > {{LS_PAD{1'b0}}, ls_cnt});
    end
endmodule

// File: rtl/frame_timer.sv
// Module: top of the full-speed frame interval timer. Joins the register
// file, counter and comparators and provides the read mux and event vector.
// Assumes tick is a one-cycle bit-time enable in the clk domain.
module frame_timer
    import ft_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [EV_W-1:0]   events,
    output logic              periodic_win,
    output logic              ls_ok
);
    localparam int REM_PAD = DATA_W - 1 - CNT_W;
    localparam int FN_PAD  = DATA_W - FN_W;
    localparam int PS_PAD  = DATA_W - CNT_W;
    localparam int LS_PADR = DATA_W - LS_W;
    localparam int IV_GAP  = PKT_LSB - CNT_W;

    logic [CNT_W-1:0] ivl_cnt, pst_cnt, rem_cnt;
    logic [PKT_W-1:0] ivl_pkt;
    logic             ivl_tog, act_tog, sof, fno, fn_wr;
    logic [LS_W-1:0]  ls_cnt;
    logic [FN_W-1:0]  fnum;

    // Frame-number load strobe.
    always_comb fn_wr = wr_en && (addr == RA_FNUM);

    ft_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .ivl_cnt(ivl_cnt), .ivl_pkt(ivl_pkt), .ivl_tog(ivl_tog),
        .pst_cnt(pst_cnt), .ls_cnt(ls_cnt)
    );

    ft_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .pend_cnt(ivl_cnt), .pend_tog(ivl_tog),
        .fn_wr(fn_wr), .fn_wdata(wdata[FN_W-1:0]),
        .rem_cnt(rem_cnt), .act_tog(act_tog), .fnum(fnum),
        .sof(sof), .fno(fno)
    );

    ft_window u_win (
        .rem_cnt(rem_cnt), .pst_cnt(pst_cnt), .ls_cnt(ls_cnt),
        .periodic_win(periodic_win), .ls_ok(ls_ok)
    );

    // Build the event vector from the two pulses.
    always_comb begin
        events         = '0;
        events[EV_SOF] = sof;
        events[EV_FNO] = fno;
    end

    // Register read mux.
    always_comb begin
        case (addr)
            RA_IVL:  rdata = {ivl_tog, ivl_pkt, {IV_GAP{1'b0}}, ivl_cnt};
            RA_REM:  rdata = {act_tog, {REM_PAD{1'b0}}, rem_cnt};
            RA_FNUM: rdata = {{FN_PAD{1'b0}}, fnum};
            RA_PST:  rdata = {{PS_PAD{1'b0}}, pst_cnt};
            RA_LST:  rdata = {{LS_PADR{1'b0}}, ls_cnt};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/ft_checker.sv
// Module: temporal checks on the frame timer, bound to the top module.
module ft_checker
    import ft_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             tick,
    input logic             fn_wr,
    input logic [CNT_W-1:0] rem_cnt,
    input logic [CNT_W-1:0] pend_cnt,
    input logic [FN_W-1:0]  fnum,
    input logic [EV_W-1:0]  events
);
    a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && rem_cnt == '0) |=> (rem_cnt == $past(pend_cnt)));

    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && rem_cnt != '0) |=> (rem_cnt == $past(rem_cnt) - 1'b1));

    a_r10_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(rem_cnt));

    a_r10_hold_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !fn_wr) |=> $stable(fnum));

    a_r6_sof_after_reload: assert property (@(posedge clk) disable iff (!rst_n)
        events[EV_SOF] |-> $past(run && tick && rem_cnt == '0));

    a_r7_fno_bit15: assert property (@(posedge clk) disable iff (!rst_n)
        events[EV_FNO] |-> (fnum[FN_W-1] != $past(fnum[FN_W-1])));

    a_r7_fno_with_sof: assert property (@(posedge clk) disable iff (!rst_n)
        events[EV_FNO] |-> events[EV_SOF]);

    a_r7_only_two_bits: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(events) == $countones(events & 8'h24));
endmodule

bind frame_timer ft_checker u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .fn_wr(fn_wr),
    .rem_cnt(rem_cnt), .pend_cnt(ivl_cnt), .fnum(fnum), .events(events)
);

// File: tb/tb_frame_timer.sv
module tb_frame_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0, tick = 1'b0, wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  events;
    logic        periodic_win, ls_ok;

    int checks = 0, errors = 0;
    bit done = 0;

    // reference state
    logic [13:0] m_cnt, m_ps, m_rem;
    logic [14:0] m_pkt;
    logic        m_tog, m_atog, m_sof, m_fno;
    logic [11:0] m_ls;
    logic [15:0] m_fn;

    frame_timer dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: m_read = {m_tog, m_pkt, 2'b00, m_cnt};
            3'd1: m_read = {m_atog, 17'd0, m_rem};
            3'd2: m_read = {16'd0, m_fn};
            3'd3: m_read = {18'd0, m_ps};
            3'd4: m_read = {20'd0, m_ls};
            default: m_read = '0;
        endcase
    endfunction

    // advance the reference by one clock, using the inputs seen at the edge
    task automatic m_update();
        logic [15:0] nf;
        logic ns, nfo;
        if (!rst_n) begin
            m_cnt = 14'h2EDF; m_pkt = 15'h2778; m_tog = 0; m_ps = 14'h2A2F;
            m_ls = 12'h628; m_rem = 14'h2EDF; m_atog = 0; m_fn = 0;
            m_sof = 0; m_fno = 0;
        end else begin
            ns = 0; nfo = 0;
            if (run && tick) begin
                if (m_rem == 0) begin
                    m_rem = m_cnt; m_atog = m_tog; ns = 1;
                    if (!(wr_en && addr == 3'd2)) begin
                        nf = m_fn + 16'd1;
                        nfo = nf[15] != m_fn[15];
                        m_fn = nf;
                    end
                end else m_rem = m_rem - 14'd1;
            end
            if (wr_en) case (addr)
                3'd0: begin m_cnt = wdata[13:0]; m_pkt = wdata[30:16]; m_tog = wdata[31]; end
                3'd2: m_fn = wdata[15:0];
                3'd3: m_ps = wdata[13:0];
                3'd4: m_ls = wdata[11:0];
                default: ;
            endcase
            m_sof = ns; m_fno = nfo;
        end
    endtask

    task automatic compare();
        string rq;
        check("R6/R7 events", {24'd0, events}, {26'd0, m_fno, 2'b00, m_sof, 2'b00});
        check("R8 periodic_win", {31'd0, periodic_win}, {31'd0, (m_rem <= m_ps)});
        check("R9 ls_ok", {31'd0, ls_ok}, {31'd0, (m_rem > {2'b00, m_ls})});
        case (addr)
            3'd1: rq = "R2/R4 remaining";
            3'd2: rq = "R5 frame number";
            default: rq = "R11 register";
        endcase
        check(rq, rdata, m_read(addr));
    endtask

    // one clock: inputs were set at the previous falling edge
    task automatic step();
        @(posedge clk);
        m_update();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1; addr = a; wdata = d;
        step();
        wr_en = 0; addr = 3'd1;
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int gap;
        @(negedge clk);
        rst_n = 0;
        step(); step(); step();
        rst_n = 1;
        // R1 reset values through every address
        for (int a = 0; a < 5; a++) begin
            addr = 3'(a);
            step();
        end
        addr = 3'd0; @(posedge clk); @(negedge clk);
        check("R1 interval reset", rdata, 32'h27782EDF);
        addr = 3'd1; #1 check("R1 remaining reset", rdata, 32'h00002EDF);
        addr = 3'd3; #1 check("R1 periodic reset", rdata, 32'h00002A2F);
        addr = 3'd4; #1 check("R1 lowspeed reset", rdata, 32'h00000628);
        addr = 3'd1;
        // R11: write to the remaining register is ignored
        wr(3'd1, 32'h0000_0005);
        check("R11 remaining write ignored", rdata, 32'h00002EDF);

        // start running; rewrite interval mid-frame (R3)
        run = 1; tick = 1;
        run_cycles(20);
        wr(3'd0, 32'h8005_0009);
        run_cycles(3);
        check("R3 no mid-frame reload", {18'd0, rdata[13:0]}, 32'h2EDF - 32'd24);
        check("R4 toggle not yet mirrored", {31'd0, rdata[31]}, 32'd0);
        // run to the first reload
        while (events[2] !== 1'b1) step();
        check("R4 toggle mirrored at reload", {31'd0, rdata[31]}, 32'd1);
        check("R2 reload value", {18'd0, rdata[13:0]}, 32'd9);
        // R2 frame period = count+1 ticks
        gap = 0;
        do begin step(); gap++; end while (events[2] !== 1'b1);
        check("R2 frame period", 32'(gap), 32'd10);

        // thresholds (R8 / R9) swept over frames
        wr(3'd3, 32'hFFFF_C004);
        wr(3'd4, 32'hFFFF_F006);
        addr = 3'd3; #1 check("R11 periodic mask", rdata, 32'h4);
        addr = 3'd4; #1 check("R11 lowspeed mask", rdata, 32'h6);
        addr = 3'd1;
        run_cycles(40);

        // sparse ticks
        for (int i = 0; i < 60; i++) begin tick = i[0]; step(); end
        tick = 1;

        // R10: run low holds everything
        run = 0;
        run_cycles(25);
        for (int i = 0; i < 10; i++) begin tick = i[0]; step(); end
        run = 1; tick = 1;

        // R5 / R7 frame number near bit-15 transitions
        addr = 3'd2;
        wr(3'd2, 32'hABCD_7FFD);
        addr = 3'd2;
        run_cycles(45);
        check("R5 frame past 0x8000", {31'd0, rdata[15:0] > 16'h8000}, 32'd1);
        wr(3'd2, 32'h0000_FFFE);
        addr = 3'd2;
        run_cycles(35);
        check("R5 frame wrapped", {31'd0, rdata[15:0] < 16'h0010}, 32'd1);

        // new interval, toggle back to 0
        addr = 3'd1;
        wr(3'd0, 32'h0001_0003);
        run_cycles(30);
        check("R4 toggle cleared after reload", {31'd0, rdata[31]}, 32'd0);
        wr(3'd0, 32'h8001_0000);
        run_cycles(20);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule